// File: doc/BRIEF.md
# Peripheral Clock-Enable Generator

This block derives one or two gated clock-enable pulse trains for peripherals from a single control word. A two-bit source code picks one of three reference tick inputs. The chosen ticks pass through two programmable divide stages in series. Each of up to two outputs is then gated by its own enable bit. Everything runs in one system clock domain: references and outputs are single-cycle enable strobes, not clocks.

Software programs the block through a plain word-wide write port and reads it back through a combinational read port. A divisor written while a stage is counting is held back until that stage completes its current period. This means no output period is ever cut short.

Top module: `periphClkGen`

## Requirements
- R1: While reset is held, the control word reads 0x00100100: both divisor fields hold 1, both enables are 0 and the source code is 0. Both outputs are low.
- R2: The control word has the following writable fields:
  - bit 0: enable for output 0
  - bit 1: enable for output 1
  - bits [5:4]: source code
  - bits [13:8]: first divisor
  - bits [25:20]: second divisor

  A write applies at the next clock edge, and every other bit reads back as zero.
- R3: Source codes 0 and 1 both pick reference input 0. Code 2 picks reference input 1, and code 3 picks reference input 2.
- R4: With a first divisor N from 1 to 63, the first stage passes one tick for every N selected reference ticks (one-based count).
- R5: The second stage counts the first stage's ticks with its own one-based divisor M. An output therefore pulses once per N*M selected reference ticks, including at N=M=63.
- R6: A divisor field of 0 acts exactly as a divisor of 1: every incoming tick passes, with no stall.
- R7: A new divisor value is adopted by a stage only when that stage reaches its terminal count. The period in progress completes with the old divisor.
- R8: Output k pulses only while enable bit k is 1. Clearing one enable does not disturb the other output or the divider count.
- R9: An output is a registered pulse. It goes high for exactly one cycle in the cycle after the reference tick that completes the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word write data |
| rdData | output | 32 | Current control word |
| refTick | input | 3 | Reference clock-enable ticks |
| outTick | output | NUM_OUT (2) | Gated divided enable pulses |

## Verification
The bench builds the block with its defaults: two outputs and 6-bit divisor fields. With these values, both gates and the full 63-by-63 divide range, a period of 3969 reference ticks, run within the cycle budget. A cycle-level reference model in the bench predicts every output cycle under several reference tick rates per source code. That includes sparse ticks, zero divisors and divisor changes written mid-period, so the deferred-load rule and the zero-as-one rule are checked cycle by cycle.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int REG_W    = 32;
  localparam int DIV_W    = 6;
  localparam int SEL_W    = 2;
  localparam int NUM_REF  = 3;
  localparam int MAX_OUT  = 2;
  localparam int STAGES   = 2;
  localparam int SEL_LO   = 4;
  localparam int DIVA_LO  = 8;
  localparam int DIVB_LO  = 20;

  typedef struct packed {
    logic               srcTick;
    logic [MAX_OUT-1:0] gate;
    logic [DIV_W-1:0]   divA;
    logic [DIV_W-1:0]   divB;
  } pcgStrobe_t;
endpackage

// File: rtl/pcgCtrl.sv
module pcgCtrl
  import pcg_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic [NUM_REF-1:0] refTick,
  output pcgStrobe_t         strb
);
  localparam logic [REG_W-1:0] DIV_ONES = REG_W'((1 << DIV_W) - 1);
  localparam logic [REG_W-1:0] RW_MASK  = REG_W'((1 << NUM_OUT) - 1)
                                        | (REG_W'((1 << SEL_W) - 1) << SEL_LO)
                                        | (DIV_ONES << DIVA_LO)
                                        | (DIV_ONES << DIVB_LO);
  localparam logic [REG_W-1:0] RST_WORD = (REG_W'(1) << DIVA_LO) | (REG_W'(1) << DIVB_LO);

  logic [REG_W-1:0] ctrlWord;
  logic [SEL_W-1:0] selCode;
  logic             pickedTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ctrlWord <= RST_WORD;
    else if (wrEn) ctrlWord <= wrData & RW_MASK;
  end

  assign rdData  = ctrlWord;
  assign selCode = ctrlWord[SEL_LO +: SEL_W];

  // codes 0 and 1 share the primary reference
  always_comb begin
    case (selCode)
      2'd2:    pickedTick = refTick[1];
      2'd3:    pickedTick = refTick[2];
      default: pickedTick = refTick[0];
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.srcTick = pickedTick;
    strb.gate    = MAX_OUT'(ctrlWord[NUM_OUT-1:0]);
    strb.divA    = ctrlWord[DIVA_LO +: DIV_W];
    strb.divB    = ctrlWord[DIVB_LO +: DIV_W];
  end

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == ($past(wrData) & RW_MASK));
endmodule

// File: rtl/pcgDivStage.sv
module pcgDivStage
  import pcg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic [DIV_W-1:0] divField,
  output logic             tickOut
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] effDiv;
  logic             atTerm;

  assign effDiv  = (divField == '0) ? DIV_W'(1) : divField;
  assign atTerm  = (cnt == lim - DIV_W'(1));
  assign tickOut = tickIn && atTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      lim <= DIV_W'(1);
    end else if (tickIn) begin
      if (atTerm) begin
        cnt <= '0;
        lim <= effDiv;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < lim);
  // R6
  lim_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lim != '0);
  // R7
  wrap_after_term_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |=> (cnt == '0) && (lim == $past(effDiv)));
endmodule

// File: rtl/pcgDatapath.sv
module pcgDatapath
  import pcg_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  pcgStrobe_t         strb,
  output logic [NUM_OUT-1:0] outTick
);
  logic [STAGES:0]  tickChain;
  logic [DIV_W-1:0] divSel [STAGES];

  assign tickChain[0] = strb.srcTick;
  assign divSel[0]    = strb.divA;
  assign divSel[1]    = strb.divB;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    pcgDivStage u_stage (
      .clk      (clk),
      .rstN     (rstN),
      .tickIn   (tickChain[g]),
      .divField (divSel[g]),
      .tickOut  (tickChain[g+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outTick <= '0;
    else       outTick <= {NUM_OUT{tickChain[STAGES]}} & strb.gate[NUM_OUT-1:0];
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
    // R8
    gate_respect_chk: assert property (@(posedge clk) disable iff (!rstN)
      outTick[k] |-> $past(strb.gate[k]));
  end
  // R9
  pulse_after_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outTick != '0) |-> $past(strb.srcTick));
endmodule

// File: rtl/periphClkGen.sv
module periphClkGen
  import pcg_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic [NUM_REF-1:0] refTick,
  output logic [NUM_OUT-1:0] outTick
);
  pcgStrobe_t strb;

  pcgCtrl #(.NUM_OUT(NUM_OUT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .rdData  (rdData),
    .refTick (refTick),
    .strb    (strb)
  );

  pcgDatapath #(.NUM_OUT(NUM_OUT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .outTick (outTick)
  );
endmodule

// File: tb/periphClkGen_tb.sv
`timescale 1ns/1ps
module periphClkGen_tb;
  localparam logic [31:0] MASK = 32'h03F03F33;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic [2:0]  refTick;
  logic [1:0]  outTick;

  int total = 0;
  int bad   = 0;

  typedef struct { logic [1:0] exp; string tag; } item_t;
  item_t q[$];

  // bench model state
  logic [31:0] mReg;
  int mCntA, mLimA, mCntB, mLimB;
  int per0, per1, per2;
  int cyc;

  always #10 clk = ~clk;

  periphClkGen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .refTick(refTick), .outTick(outTick)
  );

  function automatic int eff(input logic [5:0] d);
    return (d == 6'd0) ? 1 : int'(d);
  endfunction

  function automatic logic [31:0] cfg(input logic [1:0] en, input logic [1:0] sel,
                                      input logic [5:0] a, input logic [5:0] b);
    return {6'd0, b, 6'd0, a, 2'd0, sel, 2'd0, en};
  endfunction

  task automatic step(input logic doWr, input logic [31:0] wd, input string tag);
    logic [2:0] rv;
    logic t, ta, tb;
    item_t it;
    @(negedge clk);
    rv[0] = (cyc % per0) == 0;
    rv[1] = (cyc % per1) == 0;
    rv[2] = (cyc % per2) == 0;
    cyc++;
    refTick = rv; wrEn = doWr; wrData = wd;
    case (mReg[5:4])
      2'd2:    t = rv[1];
      2'd3:    t = rv[2];
      default: t = rv[0];
    endcase
    ta = t && (mCntA == mLimA - 1);
    if (t) begin
      if (ta) begin mCntA = 0; mLimA = eff(mReg[13:8]); end
      else mCntA++;
    end
    tb = ta && (mCntB == mLimB - 1);
    if (ta) begin
      if (tb) begin mCntB = 0; mLimB = eff(mReg[25:20]); end
      else mCntB++;
    end
    it.exp = {tb & mReg[1], tb & mReg[0]};
    it.tag = tag;
    q.push_back(it);
    if (doWr) mReg = wd & MASK;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 32'd0, tag);
  endtask

  task automatic checkRd(input logic [31:0] exp, input string tag);
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s: rdData=%h expected %h", tag, rdData, exp);
    end
  endtask

  // monitor: pop one expected item per clock and compare
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        total++;
        if (outTick !== it.exp) begin
          bad++;
          $display("FAIL %s: outTick=%b expected %b", it.tag, outTick, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; refTick = '0;
    mReg = 32'h00100100; mCntA = 0; mLimA = 1; mCntB = 0; mLimB = 1;
    per0 = 1; per1 = 1; per2 = 1; cyc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkRd(32'h00100100, "R1");
    total++;
    if (outTick !== 2'b00) begin
      bad++;
      $display("FAIL R1: outTick=%b expected 00", outTick);
    end
    rstN = 1'b1;

    // R2 write mask and readback
    step(1'b1, 32'hFFFFFFFF, "R2");
    step(1'b0, 32'd0, "R2");
    checkRd(32'h03F03F33, "R2");
    step(1'b1, 32'h0000_0000, "R2");
    step(1'b0, 32'd0, "R2");
    checkRd(32'h0000_0000, "R2");

    // R4 R5 basic chain: 3 then 2
    step(1'b1, cfg(2'b11, 2'd0, 6'd3, 6'd2), "R4 R5");
    step(1'b0, 32'd0, "R4 R5");
    checkRd(cfg(2'b11, 2'd0, 6'd3, 6'd2), "R2");
    run(60, "R4 R5 R9");

    // R3 source codes under distinct tick rates
    per0 = 2; per1 = 1; per2 = 1;
    step(1'b1, cfg(2'b11, 2'd1, 6'd3, 6'd2), "R3 code1");
    run(40, "R3 code1");
    per0 = 1; per1 = 3; per2 = 1;
    step(1'b1, cfg(2'b11, 2'd2, 6'd2, 6'd2), "R3 code2");
    run(50, "R3 code2");
    per0 = 1; per1 = 1; per2 = 4;
    step(1'b1, cfg(2'b11, 2'd3, 6'd2, 6'd1), "R3 code3");
    run(50, "R3 code3");

    // R6 zero divisors pass every tick; R9 one-cycle registered pulse
    per0 = 1; per1 = 1; per2 = 1;
    step(1'b1, cfg(2'b11, 2'd0, 6'd0, 6'd0), "R6");
    run(12, "R6 R9");
    per0 = 3;
    run(15, "R6 R9");
    step(1'b1, cfg(2'b11, 2'd0, 6'd4, 6'd0), "R6");
    run(30, "R6 R4");

    // R7 divisor change mid-period
    per0 = 1;
    step(1'b1, cfg(2'b11, 2'd0, 6'd5, 6'd1), "R7");
    run(12, "R7");
    step(1'b1, cfg(2'b11, 2'd0, 6'd2, 6'd1), "R7");
    run(20, "R7");
    step(1'b1, cfg(2'b11, 2'd0, 6'd2, 6'd3), "R7");
    run(3, "R7");
    step(1'b1, cfg(2'b11, 2'd0, 6'd2, 6'd1), "R7");
    run(20, "R7");

    // R8 gating of each output
    step(1'b1, cfg(2'b01, 2'd0, 6'd2, 6'd2), "R8");
    run(20, "R8 out0 only");
    step(1'b1, cfg(2'b10, 2'd0, 6'd2, 6'd2), "R8");
    run(20, "R8 out1 only");
    step(1'b1, cfg(2'b00, 2'd0, 6'd2, 6'd2), "R8");
    run(15, "R8 none");
    step(1'b1, cfg(2'b11, 2'd0, 6'd2, 6'd2), "R8");
    run(15, "R8 both");

    // R5 maximal divisors
    step(1'b1, cfg(2'b11, 2'd0, 6'd63, 6'd63), "R5 max");
    run(8200, "R5 max");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule